// File: doc/BRIEF.md
# Adaptive Radix-16 Unsigned Divider

This block divides an unsigned dividend by an unsigned divisor of the same width. The width is 32 bits by default and can be set to any multiple of four, such as 24. It produces four quotient bits per clock. To do that, it subtracts all fifteen nonzero multiples of the divisor from the current partial remainder at once. A priority encoder then picks the largest multiple that leaves a non-negative result.

In the cycle that accepts an operation, the block finds the highest nonzero nibble of the dividend. It left-aligns the dividend so that the empty nibbles above it are never iterated, and loads an iteration count equal to the number of nibbles that remain. The latency therefore depends on the size of the dividend: one cycle to load and one cycle per remaining nibble, which is 2 to 9 cycles at the default width.

A caller pulses `start_i` with both operands while the block is idle and waits for `done_o`. The results stay on the outputs until the next operation is accepted.

Top module: `adapt_div16`

## Requirements
- R1: With a nonzero divisor, when `done_o` is high, `quotient_o` equals floor(dividend / divisor) and `remainder_o` equals dividend mod divisor, so the remainder is below the divisor.
- R2: Let k be the number of dividend nibbles up to and including its highest nonzero nibble, with k = 1 for a zero dividend. Counting from the rising edge that samples `start_i` high while idle, `done_o` is high right after the k-th following rising edge. That gives a total latency of k+1 cycles, at most W/4+1.
- R3: A zero dividend runs a single iteration: `done_o` follows two cycles after start, with quotient 0 and remainder 0.
- R4: A zero divisor sets `div_zero_o` high together with `done_o`, returns an all-ones quotient and returns the dividend unchanged as the remainder. The latency follows the same rule as R2. A nonzero divisor leaves `div_zero_o` low.
- R5: `busy_o` is high in every cycle from the accepting edge until the edge that raises `done_o`. `done_o` is high for exactly one cycle, and `busy_o` is low while `done_o` is high.
- R6: `start_i` is ignored while `busy_o` is high: the operation in progress completes with its own operands and its own latency.
- R7: While idle with `start_i` low, `quotient_o`, `remainder_o` and `div_zero_o` hold their values.
- R8: After reset, `busy_o`, `done_o`, `div_zero_o`, `quotient_o` and `remainder_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the block is idle |
| dividend_i | input | W | Unsigned dividend, sampled with start |
| divisor_i | input | W | Unsigned divisor, sampled with start |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse: results are valid |
| quotient_o | output | W | Quotient (all ones on a zero divisor) |
| remainder_o | output | W | Remainder (the dividend on a zero divisor) |
| div_zero_o | output | 1 | The last operation had a zero divisor |

## Verification
A dense sweep pairs every 8-bit dividend with divisors 0 to 31. These quotients draw on every digit value from 0 to 15 and exercise the zero-dividend and zero-divisor cases, all at the short latencies. A second sweep puts a leading nibble of each value at each of the eight nibble positions, with filler below it. Paired with divisors from 1 up to all ones, this separates a wrong skip count, which shows up as a latency error, from a wrong multiple or selection, which shows up as a result error. Operations that raise `start_i` with different operands during busy show whether a busy start is ignored. Idle gaps after completion show whether the results are held.

// File: rtl/adapt_div16_pkg.sv
package adapt_div16_pkg;
   localparam int unsigned DIGIT_BITS = 4;
   localparam int unsigned MULT_MAX   = (1 << DIGIT_BITS) - 1;

   function automatic int unsigned nib_count(input int unsigned width);
      return width / DIGIT_BITS;
   endfunction
endpackage

// File: rtl/adiv16_skip.sv
module adiv16_skip
   import adapt_div16_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0]  dvd_i,
   output logic [W-1:0]  aligned_o,
   output logic [$clog2(nib_count(W)+1)-1:0] iters_o
);
   localparam int unsigned NIB = nib_count(W);
   localparam int unsigned IW  = $clog2(NIB);
   localparam int unsigned CW  = $clog2(NIB + 1);

   logic [NIB-1:0] nz;
   logic [IW-1:0]  top_idx;
   logic [IW-1:0]  skip;
   logic [IW+1:0]  shamt;

   for (genvar g = 0; g < NIB; g++) begin : g_nib
      assign nz[g] = |dvd_i[4*g +: 4];
   end

   always_comb begin
      top_idx = '0;
      for (int i = 0; i < NIB; i++) begin
         if (nz[i]) top_idx = IW'(i);
      end
   end

   assign skip      = IW'(NIB - 1) - top_idx;
   assign shamt     = {skip, 2'b00};
   assign aligned_o = dvd_i << shamt;
   assign iters_o   = CW'(top_idx) + CW'(1);
endmodule

// File: rtl/adiv16_multiples.sv
module adiv16_multiples #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0]          dvs_i,
   output logic [15:1][W+3:0]    mult_o
);
   localparam int unsigned MW = W + 4;

   logic [MW-1:0] x1, x2, x4, x8, x16;

   assign x1  = MW'(dvs_i);
   assign x2  = x1 << 1;
   assign x4  = x1 << 2;
   assign x8  = x1 << 3;
   assign x16 = x1 << 4;

   always_comb begin
      mult_o[1]  = x1;
      mult_o[2]  = x2;
      mult_o[3]  = x2 + x1;
      mult_o[4]  = x4;
      mult_o[5]  = x4 + x1;
      mult_o[6]  = x4 + x2;
      mult_o[7]  = x8 - x1;
      mult_o[8]  = x8;
      mult_o[9]  = x8 + x1;
      mult_o[10] = x8 + x2;
      mult_o[11] = x8 + x2 + x1;
      mult_o[12] = x8 + x4;
      mult_o[13] = x8 + x4 + x1;
      mult_o[14] = x16 - x2;
      mult_o[15] = x16 - x1;
   end
endmodule

// File: rtl/adiv16_select.sv
module adiv16_select #(
   parameter int unsigned W = 32
) (
   input  logic [W+3:0]          window_i,
   input  logic [15:1][W+3:0]    mult_i,
   output logic [3:0]            digit_o,
   output logic [W+4:0]          trial_o
);
   logic [W+4:0] diff [16];
   logic [15:1]  nonneg;

   assign diff[0] = {1'b0, window_i};

   for (genvar k = 1; k < 16; k++) begin : g_sub
      assign diff[k]   = {1'b0, window_i} - {1'b0, mult_i[k]};
      assign nonneg[k] = ~diff[k][W+4];
   end

   always_comb begin
      digit_o = 4'd0;
      for (int k = 1; k < 16; k++) begin
         if (nonneg[k]) digit_o = 4'(k);
      end
   end

   assign trial_o = diff[digit_o];
endmodule

// File: rtl/adapt_div16.sv
module adapt_div16
   import adapt_div16_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] dividend_i,
   input  logic [W-1:0] divisor_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] quotient_o,
   output logic [W-1:0] remainder_o,
   output logic         div_zero_o
);
   localparam int unsigned NIB = nib_count(W);
   localparam int unsigned CW  = $clog2(NIB + 1);

   if ((W % DIGIT_BITS) != 0 || W < 8) begin : g_bad_width
      $error("adapt_div16: W must be a multiple of 4 and at least 8");
   end

   logic [2*W-1:0]     work_q;
   logic [W-1:0]       dvs_q;
   logic [W-1:0]       quo_q;
   logic [CW-1:0]      cnt_q;
   logic               busy_q, done_q, dz_q;

   logic [W-1:0]       aligned;
   logic [CW-1:0]      iters;
   logic [15:1][W+3:0] mult;
   logic [3:0]         digit;
   logic [W+4:0]       trial;
   logic [W-1:0]       rem_next;
   logic [W+3:0]       window;

   adiv16_skip #(.W(W)) u_skip (
      .dvd_i     (dividend_i),
      .aligned_o (aligned),
      .iters_o   (iters)
   );

   adiv16_multiples #(.W(W)) u_mult (
      .dvs_i  (dvs_q),
      .mult_o (mult)
   );

   assign window = work_q[2*W-1 : W-4];

   adiv16_select #(.W(W)) u_sel (
      .window_i (window),
      .mult_i   (mult),
      .digit_o  (digit),
      .trial_o  (trial)
   );

   assign rem_next = trial[W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q <= '0;
         dvs_q  <= '0;
         quo_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         dz_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q && start_i) begin
            work_q <= {{W{1'b0}}, aligned};
            dvs_q  <= divisor_i;
            quo_q  <= '0;
            cnt_q  <= iters;
            busy_q <= 1'b1;
            dz_q   <= (divisor_i == '0);
         end else if (busy_q) begin
            work_q <= {rem_next, work_q[W-5:0], 4'b0000};
            quo_q  <= {quo_q[W-5:0], digit};
            cnt_q  <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy_o      = busy_q;
   assign done_o      = done_q;
   assign div_zero_o  = dz_q;
   assign quotient_o  = dz_q ? {W{1'b1}} : quo_q;
   assign remainder_o = work_q[2*W-1:W];

   // busy-length watch for the latency bound
   logic [CW:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= '0;
      else if (!busy_q) run_q <= '0;
      else              run_q <= run_q + 1'b1;
   end

   AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && dvs_q != '0 |-> rem_next < dvs_q); // R1
   AST_NO_TRIAL_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && dvs_q != '0 |-> trial[W+4:W] == '0); // R1
   AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> run_q < (CW+1)'(NIB)); // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R5
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R5
   AST_BUSY_KEEPS_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(dvs_q)); // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && !start_i |=> $stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o)); // R7
endmodule

// File: tb/test_adapt_div16.sv
`timescale 1ns/1ps
module test_adapt_div16;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] dvd = '0, dvs = '0;
   logic        busy, done, dz;
   logic [31:0] quo, rem;

   int n_checks = 0;
   int n_fails  = 0;

   always #2.5 clk = ~clk;

   adapt_div16 #(.W(32)) i_adapt_div16 (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .dividend_i(dvd), .divisor_i(dvs),
      .busy_o(busy), .done_o(done),
      .quotient_o(quo), .remainder_o(rem), .div_zero_o(dz)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic int exp_iters(input logic [31:0] a);
      int n = 1;
      for (int i = 0; i < 8; i++) if (a[4*i +: 4] != 4'd0) n = i + 1;
      return n;
   endfunction

   task automatic run_div(input logic [31:0] a, input logic [31:0] b,
                          input bit poke, input bit hold);
      logic [31:0] eq, er;
      int n, c;
      bit got;
      string tq;
      eq = (b == 0) ? 32'hFFFF_FFFF : a / b;
      er = (b == 0) ? a : a % b;
      n  = exp_iters(a);
      tq = (b == 0) ? "R4" : ((a == 0) ? "R3" : "R1");
      @(negedge clk);
      start = 1'b1; dvd = a; dvs = b;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         start = 1'b1; dvd = ~a; dvs = b + 32'd1;   // R6 busy start
      end
      c = 0; got = 0;
      while (!got && c < 40) begin
         @(posedge clk); c++;
         @(negedge clk);
         start = 1'b0;
         if (done) got = 1;
         else if (!busy) chk(0, "R5", "busy low before done", 32'(busy), 32'd1);
      end
      chk(got, "R2", "done seen", 32'(got), 32'd1);
      chk(c == n, poke ? "R6" : ((a == 0) ? "R3" : "R2"), "latency", 32'(c), 32'(n));
      chk(quo == eq, poke ? "R6" : tq, "quotient", quo, eq);
      chk(rem == er, poke ? "R6" : tq, "remainder", rem, er);
      chk(dz == (b == 0), "R4", "div_zero", 32'(dz), 32'(b == 0));
      chk(!busy, "R5", "busy with done", 32'(busy), 32'd0);
      @(negedge clk);
      chk(!done, "R5", "done width", 32'(done), 32'd0);
      if (hold) begin
         repeat (2) @(negedge clk);
         chk(quo == eq, "R7", "held quotient", quo, eq);
         chk(rem == er, "R7", "held remainder", rem, er);
         chk(dz == (b == 0), "R7", "held div_zero", 32'(dz), 32'(b == 0));
      end
   endtask

   initial begin
      #(5.0 * 190000);
      chk(0, "WATCHDOG", "run time", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end

   initial begin
      logic [31:0] dl [12];
      repeat (3) @(negedge clk);
      chk(busy == 0, "R8", "reset busy", 32'(busy), 0);
      chk(done == 0, "R8", "reset done", 32'(done), 0);
      chk(dz == 0, "R8", "reset div_zero", 32'(dz), 0);
      chk(quo == 0, "R8", "reset quotient", quo, 0);
      chk(rem == 0, "R8", "reset remainder", rem, 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_div(32'd0, 32'd7, 0, 1);               // R3
      run_div(32'hFFFF_FFFF, 32'd0, 0, 1);       // R4
      run_div(32'd0, 32'd0, 0, 0);               // R3 and R4

      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 32; b++)
            run_div(32'(a), 32'(b), 0, (a % 37) == 0 && b == 5);

      dl[0] = 32'd1;        dl[1] = 32'd3;         dl[2] = 32'd7;
      dl[3] = 32'd15;       dl[4] = 32'd16;        dl[5] = 32'd255;
      dl[6] = 32'h1234;     dl[7] = 32'hFFFF;      dl[8] = 32'h8000_0000;
      dl[9] = 32'hFFFF_FFFF; dl[10] = 32'h0003_0001; dl[11] = 32'd0;
      for (int p = 0; p < 8; p++)
         for (int v = 1; v < 16; v++)
            for (int d = 0; d < 12; d++) begin
               logic [31:0] a;
               logic [31:0] mask;
               mask = (p == 0) ? 32'd0 : (32'hFFFF_FFFF >> (32 - 4 * p));
               a = (32'(v) << (4 * p)) | (32'h9E37_79B9 & mask);
               run_div(a, dl[d], (d == 6) && (v == 5), (d == 2) && (v == 9));
            end

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end
endmodule